// File: doc/BRIEF.md
# Single-Transfer Classic Bus Master

This block turns a simple local command port into single classic-cycle transfers on a Wishbone bus. A client presents one command at a time: a request strobe, a write flag, an address, write data and byte-lane selects. The master raises the cycle and strobe lines and holds every bus output steady until the slave terminates the transfer. The slave can terminate with an acknowledge, an error or a retry.

A busy flag tells the client that a transfer is in flight. When the transfer ends, a one-cycle done pulse reports how it ended, as a two-bit status. For a read that was acknowledged, the slave's data is returned with it. Retrying a refused transfer is left to the client. The bus always goes idle, with the cycle line low, between two commands.

Top module: `wbm_single_master`

## Requirements
- R1: On the cycle after a clock edge with `rst` high, `bus_cyc`, `bus_stb`, `busy` and `done` are low, `rsp_status` is 2'b00 and `rsp_data` is zero.
- R2: A clock edge that samples `req_valid` high while `busy` is low accepts the command. From the next cycle, `bus_cyc`, `bus_stb` and `busy` are high. `bus_we`, `bus_adr`, `bus_dat_o` and `bus_sel` then equal the write flag, address, write data and byte selects that were sampled.
- R3: `bus_stb` is never high while `bus_cyc` is low.
- R4: While `bus_stb` is high and no termination has been sampled, `bus_stb`, `bus_we`, `bus_adr`, `bus_dat_o` and `bus_sel` keep their values from one cycle to the next.
- R5: A clock edge that samples `bus_stb` high together with one of `bus_ack`, `bus_err` or `bus_rty` ends the transfer. In the next cycle `bus_cyc`, `bus_stb` and `busy` are low and `done` is high, for that single cycle.
- R6: `rsp_status` is updated when a transfer ends, with 2'b00 for acknowledge, 2'b01 for error and 2'b10 for retry. It holds that value until the next transfer ends.
- R7: `rsp_data` takes `bus_dat_i` only when a read is terminated by acknowledge. After a write, an error or a retry, it keeps its previous value.
- R8: A request raised while `busy` is high is ignored. The bus outputs of the transfer in flight do not change, and no further transfer starts after it.
- R9: Between two transfers, `bus_cyc` is low for at least one cycle, even when the next request arrives in the cycle in which `done` is high.
- R10: The data width parameter must be 8, 16, 32 or 64. There is one byte select per eight data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Command address |
| req_wdata | input | DW | Command write data |
| req_sel | input | DW/8 | Command byte-lane selects |
| busy | output | 1 | A transfer is in flight |
| done | output | 1 | One-cycle pulse when a transfer ends |
| rsp_data | output | DW | Read data captured on acknowledge |
| rsp_status | output | 2 | 00 ack, 01 error, 10 retry |
| bus_cyc | output | 1 | Bus cycle line |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | AW | Bus address |
| bus_dat_o | output | DW | Bus write data |
| bus_sel | output | DW/8 | Bus byte selects |
| bus_dat_i | input | DW | Bus read data |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error termination |
| bus_rty | input | 1 | Slave retry termination |

## Verification
The hardest case to reach from the ports is a client request that arrives in the middle of a stalled strobe phase. The bus outputs must still be seen to stay frozen, and that same request must not reappear as a second transfer. The bench's slave model holds the strobe with random numbers of wait states. While it does, the bench raises a decoy request carrying a different address and data, then drops it before the termination. It then checks both the frozen outputs and the idle bus that follows. A directed case also issues the next request in the very cycle `done` is high, which shows the idle gap between transfers. Random picks among acknowledge, error and retry show that read data is kept over non-acknowledged endings.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    typedef enum logic [1:0] {
        WBM_OK  = 2'b00,
        WBM_ERR = 2'b01,
        WBM_RTY = 2'b10
    } wbm_status_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_STROBE = 1'b1
    } wbm_phase_e;

    function automatic bit wbm_width_ok(input int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

    // Error outranks retry, retry outranks acknowledge.
    function automatic wbm_status_e wbm_classify(input logic ack, input logic err, input logic rty);
        if (err)      return WBM_ERR;
        else if (rty) return WBM_RTY;
        else          return WBM_OK;
    endfunction

endpackage

// File: rtl/wbm_cmd_reg.sv
module wbm_cmd_reg #(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          in_we,
    input  logic [AW-1:0] in_adr,
    input  logic [DW-1:0] in_dat,
    input  logic [SW-1:0] in_sel,
    output logic          q_we,
    output logic [AW-1:0] q_adr,
    output logic [DW-1:0] q_dat,
    output logic [SW-1:0] q_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_we  <= 1'b0;
            q_adr <= '0;
            q_dat <= '0;
            q_sel <= '0;
        end else if (load) begin
            q_we  <= in_we;
            q_adr <= in_adr;
            q_dat <= in_dat;
            q_sel <= in_sel;
        end
    end

endmodule

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
    import wbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic any_term,
    output logic accept,
    output logic finish,
    output logic busy,
    output logic cyc,
    output logic stb,
    output logic done
);

    wbm_phase_e phase;

    assign accept = req_valid && (phase == PH_IDLE);
    assign finish = (phase == PH_STROBE) && any_term;
    assign busy   = (phase == PH_STROBE);
    assign cyc    = (phase == PH_STROBE);
    assign stb    = (phase == PH_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            done <= finish;
            case (phase)
                PH_IDLE:   if (accept) phase <= PH_STROBE;
                PH_STROBE: if (any_term) phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    a_r1_idle_in_reset: assert property (@(posedge clk)
        rst |=> (!cyc && !stb && !done));

    a_r3_stb_inside_cyc: assert property (@(posedge clk) disable iff (rst)
        stb |-> cyc);

    a_r5_drop_after_term: assert property (@(posedge clk) disable iff (rst)
        (stb && any_term) |=> (!cyc && !stb && done));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_idle_gap: assert property (@(posedge clk) disable iff (rst)
        done |-> !cyc);

endmodule

// File: rtl/wbm_resp.sv
module wbm_resp
    import wbm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          finish,
    input  logic          is_write,
    input  logic          ack,
    input  logic          err,
    input  logic          rty,
    input  logic [DW-1:0] dat_i,
    output logic [DW-1:0] rsp_data,
    output logic [1:0]    rsp_status
);

    wbm_status_e status_q;

    assign rsp_status = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= WBM_OK;
            rsp_data <= '0;
        end else if (finish) begin
            status_q <= wbm_classify(ack, err, rty);
            if (ack && !err && !rty && !is_write) rsp_data <= dat_i;
        end
    end

    a_r6_err_code: assert property (@(posedge clk) disable iff (rst)
        (finish && err) |=> (rsp_status == 2'b01));

    a_r6_rty_code: assert property (@(posedge clk) disable iff (rst)
        (finish && rty && !err) |=> (rsp_status == 2'b10));

    a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(rsp_data));

endmodule

// File: rtl/wbm_single_master.sv
module wbm_single_master
    import wbm_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [SW-1:0] req_sel,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rsp_data,
    output logic [1:0]    rsp_status,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic          bus_we,
    output logic [AW-1:0] bus_adr,
    output logic [DW-1:0] bus_dat_o,
    output logic [SW-1:0] bus_sel,
    input  logic [DW-1:0] bus_dat_i,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic          bus_rty
);

    logic accept;
    logic finish;
    logic any_term;

    assign any_term = bus_ack || bus_err || bus_rty;

    initial begin : p_width_check
        a_r10_legal_width: assert (wbm_width_ok(DW) && (SW * 8 == DW))
            else $error("data width %0d not in {8,16,32,64}", DW);
    end

    wbm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .any_term  (any_term),
        .accept    (accept),
        .finish    (finish),
        .busy      (busy),
        .cyc       (bus_cyc),
        .stb       (bus_stb),
        .done      (done)
    );

    wbm_cmd_reg #(.AW(AW), .DW(DW)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .in_we  (req_write),
        .in_adr (req_addr),
        .in_dat (req_wdata),
        .in_sel (req_sel),
        .q_we   (bus_we),
        .q_adr  (bus_adr),
        .q_dat  (bus_dat_o),
        .q_sel  (bus_sel)
    );

    wbm_resp #(.DW(DW)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .finish     (finish),
        .is_write   (bus_we),
        .ack        (bus_ack),
        .err        (bus_err),
        .rty        (bus_rty),
        .dat_i      (bus_dat_i),
        .rsp_data   (rsp_data),
        .rsp_status (rsp_status)
    );

    a_r4_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !any_term) |=>
            (bus_stb && $stable(bus_we) && $stable(bus_adr) && $stable(bus_dat_o) && $stable(bus_sel)));

    a_r8_busy_ignores_req: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && !any_term) |=> $stable(bus_adr));

    a_r2_start_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (bus_cyc && bus_stb && busy));

endmodule

// File: tb/tb_wbm_single_master.sv
module tb_wbm_single_master;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [SW-1:0] req_sel = '0;
    logic          busy, done;
    logic [DW-1:0] rsp_data;
    logic [1:0]    rsp_status;
    logic          bus_cyc, bus_stb, bus_we;
    logic [AW-1:0] bus_adr;
    logic [DW-1:0] bus_dat_o;
    logic [SW-1:0] bus_sel;
    logic [DW-1:0] bus_dat_i = '0;
    logic          bus_ack = 1'b0, bus_err = 1'b0, bus_rty = 1'b0;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] exp_data = '0;

    always #4 clk = ~clk;

    wbm_single_master #(.AW(AW), .DW(DW)) dut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] code_of(input int term);
        return (term == 0) ? 2'b00 : (term == 1) ? 2'b01 : 2'b10;
    endfunction

    // term: 0 ack, 1 err, 2 rty. decoy: raise a request during the wait states.
    task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [SW-1:0] s, input int waits, input int term,
                        input logic [DW-1:0] rd, input bit decoy);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d; req_sel = s;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        check(bus_cyc && bus_stb && busy, "R2 start", {bus_cyc, bus_stb, busy}, 3'b111);
        check(bus_we == we && bus_adr == a && bus_dat_o == d && bus_sel == s, "R2 fields",
              bus_adr, a);
        for (int i = 0; i < waits; i++) begin
            if (decoy && i == 0) begin
                req_valid = 1'b1; req_write = ~we;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check(bus_stb && bus_cyc, "R3 R4 strobe held", {bus_cyc, bus_stb}, 2'b11);
            check(bus_adr == a && bus_dat_o == d && bus_sel == s && bus_we == we,
                  "R4 R8 outputs stable", bus_dat_o, d);
        end
        bus_dat_i = rd;
        bus_ack = (term == 0); bus_err = (term == 1); bus_rty = (term == 2);
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0; bus_rty = 1'b0; bus_dat_i = ~rd;
        if (term == 0 && !we) exp_data = rd;
        check(!bus_cyc && !bus_stb && !busy && done, "R5 end", {bus_cyc, bus_stb, busy, done}, 4'b0001);
        check(rsp_status == code_of(term), "R6 status", rsp_status, code_of(term));
        check(rsp_data == exp_data, "R7 data", rsp_data, exp_data);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        check(!bus_cyc && !bus_stb && !busy && !done, "R1 reset outputs",
              {bus_cyc, bus_stb, busy, done}, 4'b0);
        check(rsp_status == 2'b00 && rsp_data == '0, "R1 reset response", rsp_data, 0);
        rst = 1'b0;
        @(negedge clk);

        // directed corners
        xfer(1'b1, 32'h0000_1000, 32'hCAFE_0001, 4'hF, 0, 0, 32'h1111_1111, 1'b0);
        @(negedge clk);
        check(!done && !bus_cyc && !busy, "R5 R8 done single, no decoy transfer",
              {done, bus_cyc, busy}, 3'b0);
        xfer(1'b0, 32'h0000_2000, 32'h0, 4'h3, 2, 0, 32'hA5A5_5A5A, 1'b1);
        @(negedge clk);
        check(!bus_cyc && !busy, "R8 decoy ignored", {bus_cyc, busy}, 2'b0);
        xfer(1'b0, 32'h0000_3000, 32'h0, 4'hF, 1, 1, 32'hDEAD_BEEF, 1'b0);
        xfer(1'b0, 32'h0000_4000, 32'h0, 4'hF, 3, 2, 32'hBAD0_BAD0, 1'b1);
        // back-to-back: request raised in the done cycle
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h44; req_sel = 4'h1;
        check(!bus_cyc, "R9 gap in done cycle", bus_cyc, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_cyc && bus_stb && bus_adr == 32'h44, "R9 next start", bus_adr, 32'h44);
        bus_ack = 1'b1; bus_dat_i = 32'h0BAD_F00D;
        @(negedge clk);
        bus_ack = 1'b0;
        exp_data = 32'h0BAD_F00D;
        check(done && rsp_data == exp_data && rsp_status == 2'b00, "R6 R7 back-to-back read",
              rsp_data, exp_data);
        check(!bus_cyc, "R9 cyc low after end", bus_cyc, 0);

        // random transfers
        for (int n = 0; n < 300; n++) begin
            bit we = $urandom_range(0, 1);
            int w = $urandom_range(0, 5);
            int t = $urandom_range(0, 2);
            xfer(we, $urandom, $urandom, SW'($urandom), w, t, $urandom, (w > 0) && $urandom_range(0, 1));
            if ($urandom_range(0, 1)) @(negedge clk);
        end

        // R1 again: reset in the middle of a transfer
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h77;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!bus_cyc && !bus_stb && !busy && rsp_data == '0, "R1 mid-transfer reset",
              {bus_cyc, bus_stb, busy}, 3'b0);
        rst = 1'b0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule